// File: doc/BRIEF.md
# Opcode Pair Histogram Counter

This block gathers second-order instruction statistics. For every instruction it is given, it counts how often that opcode directly followed the one before it. The block keeps the previous 9-bit opcode. When a new opcode arrives, it builds a table key from the two opcodes and adds a programmable base to reach a 36-bit memory word. Each word holds two 18-bit counters. The lowest bit of the current opcode chooses which of the two counters is bumped. The update is a read-modify-write over a simple request/acknowledge memory port.

If the chosen counter is already all ones, it wraps to zero and is written back. The block then writes an all-ones word to a programmed marker address and shuts itself off. From then on it ignores instruction strobes until software arms it again with the `arm` pulse. Arming also clears the remembered opcode, so the first pair after arming is formed with a previous opcode of zero.

The block comes out of reset switched off. It holds five states:
- `S_OFF`: disabled.
- `S_IDLE`: armed, waiting for a strobe.
- `S_RD`: reading the word.
- `S_WR`: writing back the updated word.
- `S_MARK`: writing the overflow marker.

The transitions are:
- `arm` takes `S_OFF` or `S_IDLE` to `S_IDLE`.
- A strobe takes `S_IDLE` to `S_RD`.
- An acknowledge takes `S_RD` to `S_WR`.
- An acknowledge takes `S_WR` to `S_IDLE`, or to `S_MARK` if the counter overflowed.
- An acknowledge takes `S_MARK` to `S_OFF`.

Top module: `opc_pair_hist`

## Requirements
- R1: The word address is `base_addr + {prev[8:0], cur[8:1]}`, where the 17-bit key is zero-extended and the sum is taken modulo 2^18.
- R2: With `cur[0]`=0 the upper counter (bits 35:18) is incremented; with `cur[0]`=1 the lower counter (bits 17:0) is incremented. The other half is written back unchanged.
- R3: Each counted instruction makes exactly one read of the word, then one write of it to the same address, carrying the read value with the selected half plus one.
- R4: If the selected half reads as all ones, it is written back as zero. The next transfer writes 36'hFFFFFFFFF to `mark_addr`, after which `count_en` stays 0.
- R5: A request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack` is sampled high. Exactly one transfer completes per acknowledge.
- R6: After each counted instruction, its opcode becomes the previous opcode for the next pair.
- R7: After reset, `count_en`, `busy` and `mem_req` are 0. An `arm` pulse while not busy sets `count_en` to 1 and clears the previous opcode to zero.
- R8: While disabled, instruction strobes cause no memory request and leave the previous opcode untouched. The first instruction after re-arming pairs with opcode zero.
- R9: `count_en` is 0 whenever `busy` is 1. It returns to 1 on the cycle after the acknowledge of a non-overflowing write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Enable pulse; clears the previous opcode |
| base_addr | input | 18 | Table base word address |
| mark_addr | input | 18 | Address that receives the overflow marker |
| insn_vld | input | 1 | One-cycle strobe for a new instruction |
| insn_opc | input | 9 | Opcode of that instruction |
| count_en | output | 1 | High when armed and ready to count |
| busy | output | 1 | High while a memory update is in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 18 | Word address of the request |
| mem_wdata | output | 36 | Write data |
| mem_rdata | input | 36 | Read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Completes the current request |

## Verification
The read request appears on the cycle after the clock edge that samples `insn_vld`. Each later request appears on the cycle after the previous acknowledge. `count_en` rises again one cycle after the final write is acknowledged.

The bench's reference model predicts the whole sequence of transfers at the moment each strobe is driven. It then compares every acknowledged transfer against that prediction at the falling edge where the acknowledge is presented, when all request signals have settled. On every falling edge it also checks that `count_en` stays low while `busy` is high. The state of `count_en` is read only once `busy` has dropped and the predicted transfers are exhausted, so the check never lands inside an update.

// File: rtl/opc_hist_pkg.sv
package opc_hist_pkg;
    typedef enum logic [2:0] {
        S_OFF  = 3'd0,
        S_IDLE = 3'd1,
        S_RD   = 3'd2,
        S_WR   = 3'd3,
        S_MARK = 3'd4
    } ohc_state_t;
endpackage

// File: rtl/ohc_key_gen.sv
// Forms the table word address from the previous and current opcodes.
module ohc_key_gen #(
    parameter int OPC_W  = 9,
    parameter int ADDR_W = 18
) (
    input  logic [OPC_W-1:0]  prev_opc,
    input  logic [OPC_W-1:0]  cur_opc,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int KEY_W = 2 * OPC_W - 1;

    logic [KEY_W-1:0] key;

    always_comb begin
        key       = {prev_opc, cur_opc[OPC_W-1:1]};
        word_addr = base + ADDR_W'(key);
    end
endmodule

// File: rtl/ohc_half_inc.sv
// Bumps one of the two packed counters and reports its carry out.
module ohc_half_inc #(
    parameter int HALF_W = 18
) (
    input  logic [2*HALF_W-1:0] word_in,
    input  logic                sel_lo,
    output logic [2*HALF_W-1:0] word_out,
    output logic                carry
);
    localparam int NHALF = 2;

    logic [NHALF-1:0] c_vec;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic              pick;
        logic [HALF_W:0]   sum;

        always_comb begin
            // half 0 is bits [HALF_W-1:0], chosen when sel_lo is set
            pick = (h == 0) ? sel_lo : !sel_lo;
            sum  = {1'b0, word_in[h*HALF_W +: HALF_W]} + {{HALF_W{1'b0}}, 1'b1};
            word_out[h*HALF_W +: HALF_W] = pick ? sum[HALF_W-1:0]
                                                : word_in[h*HALF_W +: HALF_W];
            c_vec[h] = pick & sum[HALF_W];
        end
    end

    assign carry = |c_vec;
endmodule

// File: rtl/opc_pair_hist.sv
module opc_pair_hist
    import opc_hist_pkg::*;
#(
    parameter int OPC_W  = 9,
    parameter int HALF_W = 18,
    parameter int ADDR_W = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [ADDR_W-1:0]     mark_addr,
    input  logic                  insn_vld,
    input  logic [OPC_W-1:0]      insn_opc,
    output logic                  count_en,
    output logic                  busy,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [2*HALF_W-1:0]   mem_wdata,
    input  logic [2*HALF_W-1:0]   mem_rdata,
    input  logic                  mem_ack
);
    localparam int WORD_W = 2 * HALF_W;

    ohc_state_t state_q, state_d;

    logic [OPC_W-1:0]  prev_q;
    logic [OPC_W-1:0]  cur_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] word_q;
    logic              ovf_q;

    logic [ADDR_W-1:0] key_addr;
    logic [WORD_W-1:0] inc_word;
    logic              inc_carry;
    logic              take_insn;
    logic              take_arm;

    ohc_key_gen #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_key (
        .prev_opc  (prev_q),
        .cur_opc   (insn_opc),
        .base      (base_addr),
        .word_addr (key_addr)
    );

    ohc_half_inc #(.HALF_W(HALF_W)) u_inc (
        .word_in  (mem_rdata),
        .sel_lo   (cur_q[0]),
        .word_out (inc_word),
        .carry    (inc_carry)
    );

    assign take_arm  = arm && (state_q == S_OFF || state_q == S_IDLE);
    assign take_insn = !arm && insn_vld && (state_q == S_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:  if (arm) state_d = S_IDLE;
            S_IDLE: if (arm) state_d = S_IDLE;
                    else if (insn_vld) state_d = S_RD;
            S_RD:   if (mem_ack) state_d = S_WR;
            S_WR:   if (mem_ack) state_d = ovf_q ? S_MARK : S_IDLE;
            S_MARK: if (mem_ack) state_d = S_OFF;
            default: state_d = S_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            cur_q  <= '0;
            addr_q <= '0;
            word_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (take_arm) prev_q <= '0;
            if (take_insn) begin
                cur_q  <= insn_opc;
                addr_q <= key_addr;
                prev_q <= insn_opc;
            end
            if (state_q == S_RD && mem_ack) begin
                word_q <= inc_word;
                ovf_q  <= inc_carry;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = word_q;
        count_en  = 1'b0;
        unique case (state_q)
            S_OFF:  ;
            S_IDLE: count_en = 1'b1;
            S_RD:   mem_req = 1'b1;
            S_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_MARK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = mark_addr;
                mem_wdata = '1;
            end
            default: ;
        endcase
        busy = mem_req;
    end

    // R5: request fields held until acknowledged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));

    // R2: the unselected half of the write equals what was read
    a_r2_half_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD && mem_ack) |=>
        (cur_q[0] ? (mem_wdata[WORD_W-1:HALF_W] == $past(mem_rdata[WORD_W-1:HALF_W]))
                  : (mem_wdata[HALF_W-1:0] == $past(mem_rdata[HALF_W-1:0]))));

    // R4: an overflowing write is followed by the marker write
    a_r4_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR && mem_ack && ovf_q) |=>
        (mem_req && mem_we && mem_addr == mark_addr && (&mem_wdata)));

    // R8: disabled block issues no request on a strobe
    a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF && !arm) |=> !mem_req);

    // R9: counting resumes after a clean store
    a_r9_reenable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR && mem_ack && !ovf_q) |=> count_en);

    // R3: a read acknowledge is followed by a write to the same word
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD && mem_ack) |=> (mem_we && mem_addr == $past(mem_addr)));
endmodule

// File: tb/sim_opc_pair_hist.sv
module sim_opc_pair_hist;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [17:0] base_addr = 18'h30000;
    logic [17:0] mark_addr = 18'h01234;
    logic        insn_vld = 1'b0;
    logic [8:0]  insn_opc = '0;
    logic        count_en, busy, mem_req, mem_we;
    logic [17:0] mem_addr;
    logic [35:0] mem_wdata;
    logic [35:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int errors = 0;
    int checks = 0;
    int lat = 0;
    int wcnt = 0;
    int cycles = 0;

    logic [35:0] mem [int];
    logic [35:0] ref_mem [int];
    logic        exp_we [$];
    logic [17:0] exp_addr [$];
    logic [35:0] exp_data [$];
    logic [8:0]  m_prev = '0;
    logic        m_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opc_pair_hist u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .base_addr(base_addr),
        .mark_addr(mark_addr), .insn_vld(insn_vld), .insn_opc(insn_opc),
        .count_en(count_en), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] rd_ref(input logic [17:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 36'h0;
    endfunction

    // R1: key address computed from the requirement
    function automatic logic [17:0] key_addr(input logic [8:0] p, input logic [8:0] o);
        logic [17:0] k;
        k = {1'b0, p, o[8:1]};
        return base_addr + k;
    endfunction

    // memory responder and transfer checker
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && count_en) chk(0, "R9 count_en while busy", 1, 0);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (wcnt >= lat) begin
                    wcnt = 0;
                    mem_ack = 1'b1;
                    if (exp_we.size() == 0) begin
                        chk(0, "R5 R8 unexpected request", {45'h0, mem_addr}, 0);
                    end else begin
                        chk(mem_we == exp_we[0], "R3 transfer direction", mem_we, exp_we[0]);
                        chk(mem_addr == exp_addr[0], "R1 transfer address", mem_addr, exp_addr[0]);
                        if (exp_we[0])
                            chk(mem_wdata == exp_data[0], "R2 R4 write data", mem_wdata, exp_data[0]);
                        void'(exp_we.pop_front());
                        void'(exp_addr.pop_front());
                        void'(exp_data.pop_front());
                    end
                    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
                    else mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 36'h0;
                end else wcnt++;
            end else wcnt = 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic preload(input logic [17:0] a, input logic [35:0] v);
        mem[int'(a)] = v;
        ref_mem[int'(a)] = v;
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1'b1;
        m_en = 1'b1;
        m_prev = '0;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic issue(input logic [8:0] opc);
        logic [17:0] a;
        logic [35:0] w;
        logic [17:0] h;
        if (m_en) begin
            a = key_addr(m_prev, opc);
            w = rd_ref(a);
            exp_we.push_back(1'b0); exp_addr.push_back(a); exp_data.push_back('0);
            h = opc[0] ? w[17:0] : w[35:18];
            if (opc[0]) w[17:0] = h + 18'd1;
            else        w[35:18] = h + 18'd1;
            exp_we.push_back(1'b1); exp_addr.push_back(a); exp_data.push_back(w);
            ref_mem[int'(a)] = w;
            if (&h) begin
                exp_we.push_back(1'b1); exp_addr.push_back(mark_addr);
                exp_data.push_back('1);
                ref_mem[int'(mark_addr)] = '1;
                m_en = 1'b0;
            end
            m_prev = opc;
        end
        @(negedge clk);
        insn_vld = 1'b1;
        insn_opc = opc;
        @(negedge clk);
        insn_vld = 1'b0;
        repeat (2) @(negedge clk);
        while (busy || exp_we.size() != 0) @(negedge clk);
        chk(count_en == m_en, "R9 R4 R8 count_en after update", count_en, m_en);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(count_en == 0 && busy == 0 && mem_req == 0, "R7 reset outputs",
            {count_en, busy, mem_req}, 0);
        rst_n = 1'b1;
        // R8: strobe before arming is ignored
        issue(9'h155);
        do_arm();
        chk(count_en == 1, "R7 arm enables", count_en, 1);
        // R1 R2 R3 R6: sequence of pairs, first pairs with zero
        issue(9'h1A3);
        issue(9'h0F2);
        issue(9'h1FF);
        issue(9'h001);
        issue(9'h0F2);
        lat = 3;
        issue(9'h1A3);
        issue(9'h1A3);
        // R2: upper half near limit, no overflow
        preload(key_addr(m_prev, 9'h044), {18'h3FFFE, 18'h00ABC});
        issue(9'h044);
        // R7: arm mid-stream clears the previous opcode
        do_arm();
        issue(9'h0C8);
        lat = 1;
        // R4: lower half overflows
        preload(key_addr(m_prev, 9'h0E7), {18'h12345, 18'h3FFFF});
        issue(9'h0E7);
        chk(mem[int'(mark_addr)] == 36'hFFFFFFFFF, "R4 marker stored",
            mem[int'(mark_addr)], 36'hFFFFFFFFF);
        // R8: strobes ignored while disabled
        issue(9'h033);
        issue(9'h1C0);
        chk(mem_req == 0, "R8 no request while disabled", mem_req, 0);
        // R8: first instruction after re-arm pairs with zero
        do_arm();
        issue(9'h010);
        // R4: upper half overflow
        lat = 0;
        preload(key_addr(m_prev, 9'h0A0), {18'h3FFFF, 18'h00777});
        issue(9'h0A0);
        do_arm();
        issue(9'h111);
        // R3: table contents match the reference memory
        foreach (ref_mem[k])
            chk(mem.exists(k) && mem[k] == ref_mem[k], "R3 stored word",
                mem.exists(k) ? mem[k] : 36'h0, ref_mem[k]);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule